// File: doc/BRIEF.md
# Delta Sample Player

This block plays a 1-bit delta-coded sample stream from system memory. Software sets a start block, a length, a rate index and the loop and interrupt options, then starts playback. The block asks for sample bytes one at a time through a request/grant handshake. While a request is granted the host stalls its own accesses and drives the byte onto the data input. Each byte is held in a one-byte buffer, moved into an 8-bit shift register and emptied one bit per rate period. Each bit nudges a 7-bit output level up or down by two.

The rate comes from a 16-entry period table counted in clock cycles. A parameter picks one of two regional tables, and the 50 Hz set carries two detuned entries. The byte count per playback is one more than a multiple of sixteen. Looping reloads address and count when a playback ends. A non-looping playback can raise an interrupt instead.

Top module: `delta_sample_player`

## Requirements
- R1: After reset the level is 0, irq is low and dma_req is low.
- R2: A run write of 1 while no playback is active starts one. Its first fetch is at address 0xC000 + A×64, where A is the start register. Each further fetch goes to the next address.
- R3: One non-looping playback fetches exactly L×16+1 bytes, where L is the length register. After that, no request is raised.
- R4: The fetch address that follows 0xFFFF is 0x8000.
- R5: With RATE_SET=0, each output bit lasts P clock cycles. P is chosen by control bits [3:0] from 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54, with index 0 first.
- R6: With RATE_SET=1, the period set is 398, 354, 316, 298, 276, 236, 210, 198, 176, 148, 132, 118, 98, 78, 66, 50, with index 0 first. Entries 4 and 12 are the two detuned values.
- R7: The bits of a byte are used LSB first. A 1 adds 2 to the level and a 0 subtracts 2. The level clamps at 127 and at 0.
- R8: An 8-bit output cycle that begins with no byte buffered is silent, and the level holds through it.
- R9: With control bit 4 (loop) set, fetching the last byte reloads the address and the count from the start and length registers. Fetching then continues and irq stays low.
- R10: irq is set when the last byte of a non-looping playback is fetched while control bit 5 (irq enable) is 1. A control write with bit 5 = 0 clears irq. A control write with bit 5 = 1 leaves irq unchanged.
- R11: A level write sets the level to the written 7-bit value on the next cycle. It takes precedence over a bit step in the same cycle.
- R12: dma_req is high while bytes remain and the buffer is empty. A grant is dma_ack sampled high with dma_req; dma_data is captured in that same cycle. dma_req is low in the cycle after a grant.
- R13: A run write of 0 ends playback, and no further request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one tick per bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 6 | [5] irq enable, [4] loop, [3:0] rate index |
| level_we | input | 1 | Level write strobe |
| level_wdata | input | 7 | Value loaded into the level |
| start_we | input | 1 | Start block register write strobe |
| start_wdata | input | 8 | Start block A (address 0xC000 + A×64) |
| len_we | input | 1 | Length register write strobe |
| len_wdata | input | 8 | Length L (L×16+1 bytes) |
| run_we | input | 1 | Run write strobe |
| run_wdata | input | 1 | 1 starts playback if idle, 0 stops it |
| dma_req | output | 1 | Request for one sample byte |
| dma_addr | output | 16 | Address of the requested byte |
| dma_ack | input | 1 | Grant of the current request |
| dma_data | input | 8 | Sample byte, valid with dma_ack |
| level | output | 7 | Output level |
| irq | output | 1 | End-of-sample interrupt flag |

## Verification
The hardest case to reach is the address wrap. Reaching it takes a playback that starts in the topmost 64-byte block and runs long enough to cross 0xFFFF. The bench sets the start block to 255 and the length to 4, then lets 65 grants arrive at randomised delays so that fetch 64 falls at 0x8000. The silent output cycle is the second hard case, because it needs a request that is never granted. The bench reaches it by turning the memory responder off. It then checks that the level stays still through several full byte periods.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
    localparam int unsigned ADDR_W   = 16;
    localparam int unsigned LEVEL_W  = 7;
    localparam int unsigned RATE_W   = 4;
    localparam int unsigned PERIOD_W = 9;
    localparam int unsigned BYTE_W   = 8;

    typedef struct packed {
        logic              irq_en;
        logic              loop;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    // 60 Hz period set, cycles per output bit
    function automatic logic [PERIOD_W-1:0] period_60(input logic [RATE_W-1:0] idx);
        case (idx)
            4'd0:    return 9'd428;
            4'd1:    return 9'd380;
            4'd2:    return 9'd340;
            4'd3:    return 9'd320;
            4'd4:    return 9'd286;
            4'd5:    return 9'd254;
            4'd6:    return 9'd226;
            4'd7:    return 9'd214;
            4'd8:    return 9'd190;
            4'd9:    return 9'd160;
            4'd10:   return 9'd142;
            4'd11:   return 9'd128;
            4'd12:   return 9'd106;
            4'd13:   return 9'd84;
            4'd14:   return 9'd72;
            default: return 9'd54;
        endcase
    endfunction

    // 50 Hz period set; entries 4 and 12 are off their ideal pitch
    function automatic logic [PERIOD_W-1:0] period_50(input logic [RATE_W-1:0] idx);
        case (idx)
            4'd0:    return 9'd398;
            4'd1:    return 9'd354;
            4'd2:    return 9'd316;
            4'd3:    return 9'd298;
            4'd4:    return 9'd276;
            4'd5:    return 9'd236;
            4'd6:    return 9'd210;
            4'd7:    return 9'd198;
            4'd8:    return 9'd176;
            4'd9:    return 9'd148;
            4'd10:   return 9'd132;
            4'd11:   return 9'd118;
            4'd12:   return 9'd98;
            4'd13:   return 9'd78;
            4'd14:   return 9'd66;
            default: return 9'd50;
        endcase
    endfunction
endpackage

// File: rtl/dsp_rate_timer.sv
module dsp_rate_timer
    import dsp_pkg::*;
#(
    parameter int unsigned RATE_SET = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_idx,
    output logic              tick
);
    logic [PERIOD_W-1:0] period;

    generate
        if (RATE_SET == 0) begin : g_set60
            assign period = period_60(rate_idx);
        end else begin : g_set50
            assign period = period_50(rate_idx);
        end
    endgenerate

    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    // A tick each time the down-counter reaches zero; reload picks up a new rate
    always_comb begin
        s_d  = s_q;
        tick = (s_q.cnt == '0);
        if (tick) s_d.cnt = period - PERIOD_W'(1);
        else      s_d.cnt = s_q.cnt - PERIOD_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/dsp_fetch.sv
module dsp_fetch
    import dsp_pkg::*;
#(
    parameter int unsigned LEN_W   = 8,
    parameter int unsigned START_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_we,
    input  logic [START_W-1:0] start_wdata,
    input  logic               len_we,
    input  logic [LEN_W-1:0]   len_wdata,
    input  logic               run_we,
    input  logic               run_wdata,
    input  logic               loop_en,
    input  logic               irq_en,
    input  logic               irq_clr,
    input  logic               consume,
    input  logic               dma_ack,
    input  logic [BYTE_W-1:0]  dma_data,
    output logic               dma_req,
    output logic [ADDR_W-1:0]  dma_addr,
    output logic               buf_full,
    output logic [BYTE_W-1:0]  buf_data,
    output logic               irq
);
    localparam int unsigned SEG_SH   = 4;                 // length counts 16-byte segments
    localparam int unsigned CNT_W    = LEN_W + SEG_SH;
    localparam int unsigned BLOCK_SH = ADDR_W - 2 - START_W;

    typedef struct packed {
        logic [START_W-1:0] start;
        logic [LEN_W-1:0]   len;
        logic [ADDR_W-1:0]  cur;
        logic [CNT_W-1:0]   remain;
        logic               full;
        logic [BYTE_W-1:0]  data;
        logic               irq;
    } fch_t;

    fch_t s_d, s_q;

    logic [ADDR_W-1:0] start_addr;
    logic [CNT_W-1:0]  reload_cnt;

    assign start_addr = {2'b11, s_q.start, {BLOCK_SH{1'b0}}};
    assign reload_cnt = {s_q.len, {SEG_SH{1'b0}}} + CNT_W'(1);

    always_comb begin
        s_d     = s_q;
        dma_req = (s_q.remain != '0) && !s_q.full;

        if (start_we) s_d.start = start_wdata;
        if (len_we)   s_d.len   = len_wdata;
        if (consume)  s_d.full  = 1'b0;

        if (dma_req && dma_ack) begin
            s_d.full   = 1'b1;
            s_d.data   = dma_data;
            // top bit stays set, so 0xFFFF steps to 0x8000
            s_d.cur    = {1'b1, s_q.cur[ADDR_W-2:0] + (ADDR_W-1)'(1)};
            s_d.remain = s_q.remain - CNT_W'(1);
            if (s_q.remain == CNT_W'(1)) begin
                if (loop_en) begin
                    s_d.cur    = start_addr;
                    s_d.remain = reload_cnt;
                end else if (irq_en) begin
                    s_d.irq = 1'b1;
                end
            end
        end

        if (run_we) begin
            if (!run_wdata) begin
                s_d.remain = '0;
            end else if (s_q.remain == '0) begin
                s_d.cur    = start_addr;
                s_d.remain = reload_cnt;
            end
        end

        if (irq_clr) s_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dma_addr = s_q.cur;
    assign buf_full = s_q.full;
    assign buf_data = s_q.data;
    assign irq      = s_q.irq;
endmodule

// File: rtl/dsp_shifter.sv
module dsp_shifter
    import dsp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               buf_full,
    input  logic [BYTE_W-1:0]  buf_data,
    input  logic               level_we,
    input  logic [LEVEL_W-1:0] level_wdata,
    output logic               consume,
    output logic [LEVEL_W-1:0] level
);
    localparam int unsigned BITS_W    = $clog2(BYTE_W) + 1;
    localparam int unsigned LEVEL_MAX = (1 << LEVEL_W) - 1;

    typedef struct packed {
        logic [BYTE_W-1:0]  shreg;
        logic [BITS_W-1:0]  left;
        logic               silent;
        logic [LEVEL_W-1:0] level;
    } shf_t;

    shf_t s_d, s_q;

    function automatic logic [LEVEL_W-1:0] step(input logic [LEVEL_W-1:0] lv, input logic up);
        if (up) begin
            if (lv >= LEVEL_W'(LEVEL_MAX - 1)) return LEVEL_W'(LEVEL_MAX);
            return lv + LEVEL_W'(2);
        end
        if (lv < LEVEL_W'(2)) return '0;
        return lv - LEVEL_W'(2);
    endfunction

    always_comb begin
        s_d     = s_q;
        consume = 1'b0;
        if (tick) begin
            if (!s_q.silent) s_d.level = step(s_q.level, s_q.shreg[0]);
            s_d.shreg = s_q.shreg >> 1;
            if (s_q.left == BITS_W'(1)) begin
                s_d.left = BITS_W'(BYTE_W);
                if (buf_full) begin
                    s_d.shreg  = buf_data;
                    s_d.silent = 1'b0;
                    consume    = 1'b1;
                end else begin
                    s_d.silent = 1'b1;
                end
            end else begin
                s_d.left = s_q.left - BITS_W'(1);
            end
        end
        if (level_we) s_d.level = level_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.left   <= BITS_W'(1);
            s_q.silent <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign level = s_q.level;
endmodule

// File: rtl/delta_sample_player.sv
module delta_sample_player
    import dsp_pkg::*;
#(
    parameter int unsigned RATE_SET = 0,
    parameter int unsigned LEN_W    = 8,
    parameter int unsigned START_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic [CTRL_W-1:0]  ctrl_wdata,
    input  logic               level_we,
    input  logic [LEVEL_W-1:0] level_wdata,
    input  logic               start_we,
    input  logic [START_W-1:0] start_wdata,
    input  logic               len_we,
    input  logic [LEN_W-1:0]   len_wdata,
    input  logic               run_we,
    input  logic               run_wdata,
    output logic               dma_req,
    output logic [ADDR_W-1:0]  dma_addr,
    input  logic               dma_ack,
    input  logic [BYTE_W-1:0]  dma_data,
    output logic [LEVEL_W-1:0] level,
    output logic               irq
);
    typedef struct packed {
        ctrl_t ctrl;
    } top_t;

    top_t s_d, s_q;
    ctrl_t wr_ctrl;

    assign wr_ctrl = ctrl_t'(ctrl_wdata);

    always_comb begin
        s_d = s_q;
        if (ctrl_we) s_d.ctrl = wr_ctrl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic              tick;
    logic              consume;
    logic              buf_full;
    logic [BYTE_W-1:0] buf_data;

    dsp_rate_timer #(.RATE_SET(RATE_SET)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_idx (s_q.ctrl.rate),
        .tick     (tick)
    );

    dsp_fetch #(.LEN_W(LEN_W), .START_W(START_W)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_we    (start_we),
        .start_wdata (start_wdata),
        .len_we      (len_we),
        .len_wdata   (len_wdata),
        .run_we      (run_we),
        .run_wdata   (run_wdata),
        .loop_en     (s_q.ctrl.loop),
        .irq_en      (s_q.ctrl.irq_en),
        .irq_clr     (ctrl_we && !wr_ctrl.irq_en),
        .consume     (consume),
        .dma_ack     (dma_ack),
        .dma_data    (dma_data),
        .dma_req     (dma_req),
        .dma_addr    (dma_addr),
        .buf_full    (buf_full),
        .buf_data    (buf_data),
        .irq         (irq)
    );

    dsp_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .buf_full    (buf_full),
        .buf_data    (buf_data),
        .level_we    (level_we),
        .level_wdata (level_wdata),
        .consume     (consume),
        .level       (level)
    );
endmodule

// File: rtl/delta_sample_player_chk.sv
module delta_sample_player_chk
    import dsp_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ctrl_we,
    input logic               irq_bit,
    input logic               level_we,
    input logic [LEVEL_W-1:0] level_wdata,
    input logic               run_we,
    input logic               run_wdata,
    input logic               dma_req,
    input logic               dma_ack,
    input logic               addr_msb,
    input logic [LEVEL_W-1:0] level,
    input logic               irq
);
    localparam logic [LEVEL_W-1:0] LMAX = '1;

    // R12: a granted request is withdrawn on the next cycle
    p_req_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack) |=> !dma_req);

    // R4: requested addresses never leave the upper half
    p_addr_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> addr_msb);

    // R7: without a level write the level moves by two, clamps, or holds
    p_level_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !level_we |=> ((level == $past(level)) ||
                       (level == $past(level) + LEVEL_W'(2)) ||
                       ($past(level) == level + LEVEL_W'(2)) ||
                       (level == LMAX && $past(level) >= LMAX - LEVEL_W'(1)) ||
                       (level == '0 && $past(level) <= LEVEL_W'(1))));

    // R11: a level write lands on the next cycle
    p_level_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        level_we |=> (level == $past(level_wdata)));

    // R10: the flag only rises as a result of a grant
    p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(dma_ack));

    // R10: control write with enable clear drops the flag
    p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !irq_bit) |=> !irq);

    // R13: a stop write removes the request
    p_stop_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (run_we && !run_wdata) |=> !dma_req);
endmodule

bind delta_sample_player delta_sample_player_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we     (ctrl_we),
    .irq_bit     (ctrl_wdata[dsp_pkg::CTRL_W-1]),
    .level_we    (level_we),
    .level_wdata (level_wdata),
    .run_we      (run_we),
    .run_wdata   (run_wdata),
    .dma_req     (dma_req),
    .dma_ack     (dma_ack),
    .addr_msb    (dma_addr[dsp_pkg::ADDR_W-1]),
    .level       (level),
    .irq         (irq)
);

// File: tb/test_delta_sample_player.sv
module test_delta_sample_player;
    import dsp_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst_n       = 1'b0;
    logic               ctrl_we     = 1'b0;
    logic [CTRL_W-1:0]  ctrl_wdata  = '0;
    logic               level_we    = 1'b0;
    logic [LEVEL_W-1:0] level_wdata = '0;
    logic               start_we    = 1'b0;
    logic [7:0]         start_wdata = '0;
    logic               len_we      = 1'b0;
    logic [7:0]         len_wdata   = '0;
    logic               run_we      = 1'b0;
    logic               run_wdata   = 1'b0;
    logic               dma_ack     = 1'b0;
    logic [7:0]         dma_data    = '0;
    logic               dma_req;
    logic [ADDR_W-1:0]  dma_addr;
    logic [LEVEL_W-1:0] level;
    logic               irq;

    logic               dma_req_b;
    logic [ADDR_W-1:0]  dma_addr_b;
    logic [LEVEL_W-1:0] level_b;
    logic               irq_b;

    delta_sample_player #(.RATE_SET(0)) i_delta_sample_player (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .level_we(level_we), .level_wdata(level_wdata), .start_we(start_we),
        .start_wdata(start_wdata), .len_we(len_we), .len_wdata(len_wdata),
        .run_we(run_we), .run_wdata(run_wdata), .dma_req(dma_req), .dma_addr(dma_addr),
        .dma_ack(dma_ack), .dma_data(dma_data), .level(level), .irq(irq)
    );

    // second copy with the 50 Hz set, granted at once with a fixed 0x55 byte
    delta_sample_player #(.RATE_SET(1)) i_delta_sample_player_b (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .level_we(level_we), .level_wdata(level_wdata), .start_we(start_we),
        .start_wdata(start_wdata), .len_we(len_we), .len_wdata(len_wdata),
        .run_we(run_we), .run_wdata(run_wdata), .dma_req(dma_req_b), .dma_addr(dma_addr_b),
        .dma_ack(dma_req_b), .dma_data(8'h55), .level(level_b), .irq(irq_b)
    );

    int checks = 0;
    int errors = 0;

    // memory responder
    int          fetch_cnt = 0;
    logic [15:0] fetch_log [0:4095];
    bit          resp_on   = 1'b0;
    bit          resp_rand = 1'b0;
    int          mem_mode  = 0;

    function automatic logic [7:0] mem_byte(input logic [15:0] a, input int mode);
        case (mode)
            1:       return 8'h0F;
            2:       return 8'hFF;
            3:       return 8'h00;
            4:       return 8'h55;
            default: return a[7:0] ^ a[15:8] ^ 8'h5A;
        endcase
    endfunction

    always @(negedge clk) begin
        dma_ack <= 1'b0;
        if (resp_on && dma_req && !dma_ack &&
            (!resp_rand || $urandom_range(3, 0) != 0)) begin
            dma_ack  <= 1'b1;
            dma_data <= mem_byte(dma_addr, mem_mode);
            if (fetch_cnt < 4096) fetch_log[fetch_cnt] = dma_addr;
            fetch_cnt = fetch_cnt + 1;
        end
    end

    function automatic logic [15:0] exp_addr(input int a, input int i);
        int v;
        v = 32'hC000 + a * 64 + i;
        if (v > 32'hFFFF) v = v - 32'h10000 + 32'h8000;
        return v[15:0];
    endfunction

    task automatic step_n(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input bit ie, input bit lp, input logic [3:0] r);
        ctrl_wdata = {ie, lp, r}; ctrl_we = 1'b1; step_n(1); ctrl_we = 1'b0;
    endtask
    task automatic wr_level(input int v);
        level_wdata = v[6:0]; level_we = 1'b1; step_n(1); level_we = 1'b0;
    endtask
    task automatic wr_start(input int v);
        start_wdata = v[7:0]; start_we = 1'b1; step_n(1); start_we = 1'b0;
    endtask
    task automatic wr_len(input int v);
        len_wdata = v[7:0]; len_we = 1'b1; step_n(1); len_we = 1'b0;
    endtask
    task automatic wr_run(input bit v);
        run_wdata = v; run_we = 1'b1; step_n(1); run_we = 1'b0;
    endtask

    task automatic wait_fetch(input int base, input int n, input int limit);
        int k = 0;
        while ((fetch_cnt - base) < n && k < limit) begin
            step_n(1);
            k++;
        end
    endtask

    task automatic wait_change(input bit which, input int limit, output int cyc);
        logic [6:0] prev;
        prev = which ? level_b : level;
        cyc  = 0;
        do begin
            step_n(1);
            cyc++;
        end while (((which ? level_b : level) == prev) && cyc < limit);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
        $finish;
    end

    initial begin
        int base;
        int cyc;
        int mism;
        int a;
        int l;
        logic [6:0] seq [0:7];
        logic [6:0] exp_seq [0:7];
        void'($urandom(32'd20240611));

        step_n(5);
        rst_n = 1'b1;
        step_n(1);
        check_eq("R1 level", level, 0);
        check_eq("R1 irq", irq, 0);
        check_eq("R1 dma_req", dma_req, 0);

        // R11 direct level load
        wr_level(64);
        check_eq("R11 level load", level, 64);

        // R8 silent cycle with no grant, R2 start address, R12, R13 stop
        resp_on = 1'b0;
        wr_ctrl(0, 0, 4'd15);
        wr_start(5);
        wr_len(0);
        wr_run(1);
        step_n(1);
        check_eq("R12 req while empty", dma_req, 1);
        check_eq("R2 start address", dma_addr, 16'hC140);
        step_n(2000);
        check_eq("R8 level holds when silent", level, 64);
        check_eq("R12 req held until grant", dma_req, 1);
        wr_run(0);
        check_eq("R13 stop drops req", dma_req, 0);

        // R5 period measurement with alternating bits
        resp_on = 1'b1; resp_rand = 1'b0; mem_mode = 4;
        foreach (exp_seq[i]) exp_seq[i] = '0;
        for (int k = 0; k < 3; k++) begin
            int idx;
            int per;
            idx = (k == 0) ? 0 : (k == 1) ? 9 : 15;
            per = (k == 0) ? 428 : (k == 1) ? 160 : 54;
            wr_ctrl(0, 0, idx[3:0]);
            step_n(500);
            wr_level(64);
            wr_start(0);
            wr_len(0);
            wr_run(1);
            wait_change(1'b0, 10000, cyc);
            wait_change(1'b0, 10000, cyc);
            check_eq($sformatf("R5 period idx %0d", idx), cyc, per);
            step_n(8 * per + 200);
        end

        // R7 LSB-first stepping with byte 0x0F
        mem_mode = 1;
        wr_ctrl(0, 0, 4'd15);
        step_n(1000);
        wr_level(64);
        wr_run(1);
        for (int i = 0; i < 8; i++) begin
            wait_change(1'b0, 2000, cyc);
            seq[i] = level;
            exp_seq[i] = (i < 4) ? 7'(66 + 2 * i) : 7'(72 - 2 * (i - 3));
        end
        mism = 0;
        for (int i = 0; i < 8; i++) if (seq[i] != exp_seq[i]) mism++;
        check_eq("R7 LSB-first step mismatches", mism, 0);

        // R7 clamps at both ends
        step_n(500);
        mem_mode = 2;
        wr_level(120);
        wr_run(1);
        step_n(1500);
        check_eq("R7 clamp high", level, 127);
        mem_mode = 3;
        wr_level(5);
        wr_run(1);
        step_n(1500);
        check_eq("R7 clamp low", level, 0);

        // R3 and R2: random start blocks, lengths, grant delays
        mem_mode = 0; resp_rand = 1'b1;
        for (int it = 0; it < 5; it++) begin
            a = $urandom_range(255, 0);
            l = $urandom_range(1, 0);
            wr_start(a);
            wr_len(l);
            base = fetch_cnt;
            wr_run(1);
            wait_fetch(base, l * 16 + 1, 20000);
            step_n(1500);
            check_eq($sformatf("R3 byte count L=%0d", l), fetch_cnt - base, l * 16 + 1);
            mism = 0;
            for (int i = 0; i < l * 16 + 1; i++)
                if (fetch_log[base + i] != exp_addr(a, i)) mism++;
            check_eq("R2 address sequence mismatches", mism, 0);
        end

        // R4 wrap from the top block
        wr_start(255);
        wr_len(4);
        base = fetch_cnt;
        wr_run(1);
        wait_fetch(base, 65, 40000);
        step_n(1500);
        check_eq("R3 byte count L=4", fetch_cnt - base, 65);
        check_eq("R2 top block start", fetch_log[base], 16'hFFC0);
        check_eq("R4 last before wrap", fetch_log[base + 63], 16'hFFFF);
        check_eq("R4 wrap target", fetch_log[base + 64], 16'h8000);

        // R9 loop reloads and keeps going, no interrupt
        resp_rand = 1'b0;
        wr_ctrl(1, 1, 4'd15);
        wr_start(3);
        wr_len(0);
        base = fetch_cnt;
        wr_run(1);
        wait_fetch(base, 3, 5000);
        check_eq("R9 loop keeps fetching", (fetch_cnt - base) >= 3, 1);
        mism = 0;
        for (int i = 0; i < 3; i++) if (fetch_log[base + i] != 16'hC0C0) mism++;
        check_eq("R9 loop address reload mismatches", mism, 0);
        check_eq("R9 no irq while looping", irq, 0);
        wr_run(0);
        base = fetch_cnt;
        step_n(1500);
        check_eq("R13 no fetch after stop", fetch_cnt - base, 0);
        check_eq("R13 req low after stop", dma_req, 0);

        // R10 interrupt set, kept, cleared
        wr_ctrl(1, 0, 4'd15);
        wr_start(7);
        base = fetch_cnt;
        wr_run(1);
        wait_fetch(base, 1, 2000);
        step_n(2);
        check_eq("R10 irq on last byte", irq, 1);
        wr_ctrl(1, 0, 4'd15);
        check_eq("R10 irq kept by enable write", irq, 1);
        wr_ctrl(0, 0, 4'd15);
        check_eq("R10 irq cleared", irq, 0);
        step_n(1000);
        base = fetch_cnt;
        wr_run(1);
        wait_fetch(base, 1, 2000);
        step_n(2);
        check_eq("R10 no irq when disabled", irq, 0);

        // R6 50 Hz set on the second copy
        step_n(1000);
        wr_level(64);
        wr_len(255);
        for (int k = 0; k < 3; k++) begin
            int idx;
            int per;
            idx = (k == 0) ? 4 : (k == 1) ? 12 : 0;
            per = (k == 0) ? 276 : (k == 1) ? 98 : 398;
            wr_ctrl(0, 1, idx[3:0]);
            if (k == 0) wr_run(1);
            wait_change(1'b1, 10000, cyc);
            wait_change(1'b1, 10000, cyc);
            wait_change(1'b1, 10000, cyc);
            check_eq($sformatf("R6 period idx %0d", idx), cyc, per);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule